// File: doc/BRIEF.md
# Start-State Select Chain

This block picks the start state of one stage of a staged schedule. It takes two flag vectors over the state positions, where position 0 is the earliest time. The first vector marks the earliest state at which the stage may begin, with at most one bit set. The second vector holds the per-state decision bits from the cost comparison. The block returns a one-hot vector that marks the chosen start state. It also returns the binary index of that state and a flag that is set when no state qualifies.

Internally, a search signal runs through a chain of identical per-state cells, from state 0 towards the highest state. The signal becomes active at the marked earliest state. It stops at the first state from there on whose decision bit is set. The chain is divided into equal sections. A section can pass its incoming search value straight through when its contents cannot change that value. An active search passes a section that holds no decision bits. An idle search passes a section that holds no start marker. This shortens the worst-case path from one cell per state to about one step per section. A parameter selects a registered or a purely combinational output.

Top module: `start_select_chain`

## Requirements
- R1: At most one bit of `time_vec` is set at any time.
- R2: When `begin_vec` has bit b set, bit s of `time_vec` is set, where s is the lowest index with s >= b and `decide_vec[s]` = 1.
- R3: If `decide_vec[b]` = 1 at the marked state b, then state b itself is selected.
- R4: Decision bits at indices below the marked state have no effect on `time_vec`, `none_found` or `time_idx`.
- R5: When `begin_vec` is all zero, `time_vec` is all zero and `none_found` is 1, whatever `decide_vec` holds.
- R6: When no decision bit is set at or above the marked state, `time_vec` is all zero and `none_found` is 1. Otherwise `none_found` is 0.
- R7: `time_idx` is the binary index of the set bit of `time_vec`, and it is 0 when `none_found` is 1.
- R8: With `OUT_REG` = 1, results appear one clock edge after the inputs and hold until the next edge. While `rst_n` is low, `time_vec` is 0, `none_found` is 1 and `time_idx` is 0.
- R9: The section bypass gives the same selection as plain ripple for any `SEC_LEN` that divides `N_STATES`. This includes a marked state and a selected state that lie in different sections, possibly many sections apart.
- R10: The caller sets at most one bit of `begin_vec`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset |
| begin_vec | input | N_STATES | Earliest-start marker, at most one bit set |
| decide_vec | input | N_STATES | Per-state decision bits |
| time_vec | output | N_STATES | One-hot selected start state |
| none_found | output | 1 | No state qualifies |
| time_idx | output | $clog2(N_STATES) | Binary index of the selected state |

## Verification
The selection is tried with the decision bit at the marked state itself, a few states past it, and in the far last state. These cases tell an exact-match pick apart from a search that skips forward and from a search that stops early. Patterns that put decision bits only below the marker, or give no marker at all, show that nothing is selected outside the armed region. Marker and hit are placed on both sides of section edges, and also with every section in between empty. This separates a correct bypass from one that passes the wrong value across a section. Random sparse vectors are then compared every cycle against a behavioural search.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

   typedef enum logic {
      SSC_RIPPLE = 1'b0,
      SSC_SKIP   = 1'b1
   } ssc_chain_e;

   function automatic int ssc_sections(input int n_states, input int sec_len);
      return (sec_len > 0) ? (n_states / sec_len) : 0;
   endfunction

endpackage

// File: rtl/ssc_cell.sv
module ssc_cell (
   input  logic arm_in,
   input  logic begin_i,
   input  logic decide_i,
   output logic arm_out,
   output logic hit_o
);
   logic armed;

   assign armed   = arm_in | begin_i;
   assign hit_o   = armed & decide_i;
   assign arm_out = armed & ~decide_i;
endmodule

// File: rtl/ssc_section.sv
module ssc_section
   import ssc_pkg::*;
#(
   parameter int         LEN   = 4,
   parameter ssc_chain_e CHAIN = SSC_SKIP
) (
   input  logic           arm_in,
   input  logic [LEN-1:0] begin_seg,
   input  logic [LEN-1:0] decide_seg,
   output logic           arm_out,
   output logic [LEN-1:0] hit_seg
);
   logic [LEN:0] rip;

   assign rip[0] = arm_in;

   for (genvar k = 0; k < LEN; k++) begin : g_cell
      ssc_cell u_cell (
         .arm_in  (rip[k]),
         .begin_i (begin_seg[k]),
         .decide_i(decide_seg[k]),
         .arm_out (rip[k+1]),
         .hit_o   (hit_seg[k])
      );
   end

   if (CHAIN == SSC_SKIP) begin : g_skip
      logic pass_one;
      logic pass_zero;

      // active search crosses a section with no decision bit
      assign pass_one  = arm_in & ~(|decide_seg);
      // idle search crosses a section with no start marker
      assign pass_zero = ~arm_in & ~(|begin_seg);

      always_comb begin
         if (pass_one)       arm_out = 1'b1;
         else if (pass_zero) arm_out = 1'b0;
         else                arm_out = rip[LEN];
      end
   end else begin : g_ripple
      assign arm_out = rip[LEN];
   end
endmodule

// File: rtl/ssc_encoder.sv
module ssc_encoder #(
   parameter int N_IN  = 32,
   parameter int IDX_W = $clog2(N_IN)
) (
   input  logic [N_IN-1:0]  onehot,
   output logic [IDX_W-1:0] index
);
   always_comb begin
      index = '0;
      for (int i = 0; i < N_IN; i++) begin
         if (onehot[i]) index = index | IDX_W'(i);
      end
   end
endmodule

// File: rtl/start_select_chain.sv
module start_select_chain
   import ssc_pkg::*;
#(
   parameter int         N_STATES = 32,
   parameter int         SEC_LEN  = 4,
   parameter bit         OUT_REG  = 1'b1,
   parameter ssc_chain_e CHAIN    = SSC_SKIP
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [N_STATES-1:0]         begin_vec,
   input  logic [N_STATES-1:0]         decide_vec,
   output logic [N_STATES-1:0]         time_vec,
   output logic                        none_found,
   output logic [$clog2(N_STATES)-1:0] time_idx
);
   localparam int N_SEC = ssc_sections(N_STATES, SEC_LEN);
   localparam int IDX_W = $clog2(N_STATES);

   if (N_STATES < 2) begin : g_bad_n
      $error("start_select_chain: N_STATES must be at least 2");
   end
   if (SEC_LEN < 1 || (N_STATES % SEC_LEN) != 0) begin : g_bad_sec
      $error("start_select_chain: SEC_LEN must divide N_STATES");
   end

   logic [N_SEC:0]        link;
   logic [N_STATES-1:0]   hit_c;
   logic                  none_c;
   logic [IDX_W-1:0]      idx_c;

   assign link[0] = 1'b0;

   for (genvar s = 0; s < N_SEC; s++) begin : g_sec
      ssc_section #(
         .LEN  (SEC_LEN),
         .CHAIN(CHAIN)
      ) u_sec (
         .arm_in    (link[s]),
         .begin_seg (begin_vec[s*SEC_LEN +: SEC_LEN]),
         .decide_seg(decide_vec[s*SEC_LEN +: SEC_LEN]),
         .arm_out   (link[s+1]),
         .hit_seg   (hit_c[s*SEC_LEN +: SEC_LEN])
      );
   end

   assign none_c = ~(|hit_c);

   ssc_encoder #(
      .N_IN (N_STATES),
      .IDX_W(IDX_W)
   ) u_enc (
      .onehot(hit_c),
      .index (idx_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            time_vec   <= '0;
            none_found <= 1'b1;
            time_idx   <= '0;
         end else begin
            time_vec   <= hit_c;
            none_found <= none_c;
            time_idx   <= idx_c;
         end
      end
   end else begin : g_comb
      assign time_vec   = hit_c;
      assign none_found = none_c;
      assign time_idx   = idx_c;
   end
endmodule

// File: rtl/start_select_chain_chk.sv
module start_select_chain_chk #(
   parameter int N_STATES = 32,
   parameter bit OUT_REG  = 1'b1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [N_STATES-1:0]         begin_vec,
   input logic [N_STATES-1:0]         decide_vec,
   input logic [N_STATES-1:0]         time_vec,
   input logic                        none_found,
   input logic [$clog2(N_STATES)-1:0] time_idx
);
   logic [N_STATES-1:0] b_q;
   logic [N_STATES-1:0] d_q;
   logic                seen;
   logic [N_STATES-1:0] below_mask;

   if (OUT_REG) begin : g_lag
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            b_q  <= '0;
            d_q  <= '0;
            seen <= 1'b0;
         end else begin
            b_q  <= begin_vec;
            d_q  <= decide_vec;
            seen <= 1'b1;
         end
      end
   end else begin : g_now
      assign b_q  = begin_vec;
      assign d_q  = decide_vec;
      assign seen = 1'b1;
   end

   assign below_mask = (b_q == '0) ? '0 : (b_q - 1'b1);

   // R1
   onehot_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(time_vec))
      else $error("time_vec has more than one bit set");

   // R6
   none_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      none_found == (time_vec == '0))
      else $error("none_found disagrees with time_vec");

   // R5
   no_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && b_q == '0) |-> none_found)
      else $error("selection without a start marker");

   // R2
   hit_has_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !none_found) |-> ((time_vec & d_q) == time_vec))
      else $error("selected state has no decision bit");

   // R4
   hit_not_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !none_found) |-> ((time_vec & below_mask) == '0))
      else $error("selected state lies below the marker");

   // R7
   idx_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      none_found ? (time_idx == '0) : time_vec[time_idx])
      else $error("time_idx does not point at the selected state");

   // R10
   begin_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(begin_vec))
      else $error("begin_vec has more than one bit set");
endmodule

bind start_select_chain start_select_chain_chk #(
   .N_STATES(N_STATES),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .begin_vec (begin_vec),
   .decide_vec(decide_vec),
   .time_vec  (time_vec),
   .none_found(none_found),
   .time_idx  (time_idx)
);

// File: tb/start_select_chain_bench.sv
module start_select_chain_bench;
   localparam int N  = 32;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  bvec = '0;
   logic [N-1:0]  dvec = '0;
   logic [N-1:0]  tv;
   logic          nf;
   logic [IW-1:0] ti;

   int checks   = 0;
   int failures = 0;

   always #5 clk = ~clk;

   start_select_chain #(
      .N_STATES(N),
      .SEC_LEN (4),
      .OUT_REG (1'b1)
   ) u_start_select_chain (
      .clk       (clk),
      .rst_n     (rst_n),
      .begin_vec (bvec),
      .decide_vec(dvec),
      .time_vec  (tv),
      .none_found(nf),
      .time_idx  (ti)
   );

   // behavioural search: -1 when nothing qualifies
   function automatic int ref_pick(input logic [N-1:0] b, input logic [N-1:0] d);
      int start = -1;
      for (int i = 0; i < N; i++) if (b[i] && start < 0) start = i;
      if (start < 0) return -1;
      for (int j = start; j < N; j++) if (d[j]) return j;
      return -1;
   endfunction

   task automatic compare(input string tag, input int e);
      logic [N-1:0]  ev = (e >= 0) ? (N'(1) << e) : '0;
      logic          en = (e < 0);
      logic [IW-1:0] ei = (e >= 0) ? IW'(e) : '0;
      checks++;
      if (tv !== ev || nf !== en || ti !== ei) begin
         failures++;
         $display("FAIL %s: actual vec=%h none=%0b idx=%0d expected vec=%h none=%0b idx=%0d",
                  tag, tv, nf, ti, ev, en, ei);
      end
   endtask

   // drive at a falling edge, compare at the next falling edge
   task automatic apply(input logic [N-1:0] b, input logic [N-1:0] d, input string tag);
      @(negedge clk);
      bvec = b;
      dvec = d;
      @(negedge clk);
      compare(tag, ref_pick(b, d));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compare("R8 reset state", -1);
      rst_n = 1'b1;

      apply(N'(1) << 2, N'(1) << 4, "R2 marker 2 hit 4");
      apply(N'(1) << 5, (N'(1) << 5) | (N'(1) << 9), "R3 marker state selected");
      apply(N'(1) << 31, N'(1) << 31, "R3 last state");
      apply(N'(1) << 20, (N'(1) << 20) - 1, "R4 decisions only below marker R6");
      apply(N'(1) << 10, (N'(1) << 3) | (N'(1) << 17), "R4 lower decision ignored");
      apply('0, '1, "R5 no marker");
      apply(N'(1) << 0, '0, "R6 no decision bits");
      apply(N'(1) << 13, '1, "R2 all decisions set R7");
      apply(N'(1) << 0, N'(1) << 31, "R9 search crosses all sections");
      apply(N'(1) << 3, N'(1) << 4, "R9 hit after section edge");
      apply(N'(1) << 7, (N'(1) << 8) | (N'(1) << 28), "R9 next section first");
      apply(N'(1) << 4, (N'(1) << 3) | (N'(1) << 27), "R9 R4 empty sections between");

      // R8: new inputs do not show before the clock edge
      @(negedge clk);
      bvec = N'(1) << 1;
      dvec = N'(1) << 6;
      #2;
      compare("R8 output held before edge", ref_pick(N'(1) << 4, (N'(1) << 3) | (N'(1) << 27)));
      @(negedge clk);
      compare("R8 output after one edge", 6);

      // random sparse patterns; marker kept one-hot or empty (R10)
      for (int k = 0; k < 400; k++) begin
         logic [N-1:0] b;
         logic [N-1:0] d;
         int pos = int'($urandom_range(0, N));
         b = (pos < N) ? (N'(1) << pos) : '0;
         d = N'($urandom) & N'($urandom);
         if (k % 3 == 0) d = d & N'($urandom);
         apply(b, d, "R2 R9 random pattern");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #2000000;
      failures++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule